// File: doc/BRIEF.md
# Single-Word DMA Handshake Controller

This block copies one data word from a peripheral register into a memory location without involving an interrupt routine. Before any transfer, the processor writes two addresses into the block: the source (the peripheral register) and the destination (the memory word).

When the peripheral raises its request, the block asks the processor for the system bus. It then waits for the grant. The processor gives the grant only after it finishes its current instruction.

Once the bus is granted, the block does the following in order:
- It acknowledges the peripheral.
- It performs a single-cycle read from the source.
- It performs a single-cycle write of that word to the destination.
- It drops its bus request and the peripheral acknowledge in the same cycle.

After that, the processor withdraws the grant and the peripheral withdraws its request. When both are low, the block emits a one-cycle completion pulse and can accept the next request.

Top module: `dma_handshake_ctrl`

## Requirements
- R1: After reset, `bus_req`, `per_ack`, `bus_rd`, `bus_we`, `done` are 0 and `bus_addr`, `bus_wdata` are 0.
- R2: A high `per_req` sampled in idle (with `bus_grant` low) raises `bus_req` on the next cycle. While `bus_grant` stays low, `per_ack`, `bus_rd` and `bus_we` stay 0.
- R3: The first cycle after `bus_grant` is sampled high has `per_ack`=1, `bus_rd`=1 and `bus_addr` equal to the source address.
- R4: The next cycle has `bus_we`=1, `bus_addr` equal to the destination address, and `bus_wdata` equal to the `bus_rdata` returned by the read.
- R5: In the cycle after the write, `bus_req` and `per_ack` fall together.
- R6: After release, no new `bus_req` is raised and `done` stays 0 until `bus_grant` and `per_req` have both been sampled low. A request held high past the release is therefore not serviced twice.
- R7: `done` is high for exactly one cycle: the cycle after `bus_grant` and `per_req` are first sampled both low following a release.
- R8: A configuration write (`cfg_we`=1) stores `cfg_wdata` as the source address when `cfg_sel`=0 and as the destination address when `cfg_sel`=1. The write is accepted only while idle; writes made during a transfer are ignored.
- R9: `bus_addr`, `bus_rd`, `bus_we` and `bus_wdata` are all 0 whenever `bus_grant` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = source address, 1 = destination address |
| cfg_wdata | input | AW | Address value to store |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Acknowledge to peripheral |
| bus_req | output | 1 | Bus request to processor |
| bus_grant | input | 1 | Bus grant from processor |
| bus_addr | output | AW | Bus address |
| bus_rd | output | 1 | Bus read strobe |
| bus_we | output | 1 | Bus write strobe |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, valid in the read cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker watches four properties on every cycle:
- The bus stays silent whenever the grant is low.
- Acknowledge and bus request fall together.
- Every write directly follows a read.
- The completion pulse never lasts two cycles, and a bus request never rises while the grant is still held.

Only the directed scenarios can show the following:
- The right addresses are used and the read word is copied unchanged.
- Configuration writes made mid-transfer have no effect.
- A request held high after release is not serviced again.
- The completion pulse appears in exactly the expected cycle.

// File: rtl/dma_handshake_ctrl.sv
module dma_handshake_ctrl #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          per_req,
  output logic          per_ack,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          done
);
  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_READ, S_WRITE, S_DRAIN} state_t;

  state_t        st;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cfg_we && st == S_IDLE) begin
        if (cfg_sel) dst_q <= cfg_wdata;
        else         src_q <= cfg_wdata;
      end
      case (st)
        S_IDLE:  if (per_req && !bus_grant) st <= S_WAIT;
        S_WAIT:  if (bus_grant) st <= S_READ;
        S_READ:  begin
          data_q <= bus_rdata;
          st     <= S_WRITE;
        end
        S_WRITE: st <= S_DRAIN;
        S_DRAIN: if (!bus_grant && !per_req) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic rd_cyc, wr_cyc;
  assign rd_cyc    = (st == S_READ)  && bus_grant;
  assign wr_cyc    = (st == S_WRITE) && bus_grant;

  assign bus_req   = (st == S_WAIT) || (st == S_READ) || (st == S_WRITE);
  assign per_ack   = (st == S_READ) || (st == S_WRITE);
  assign bus_rd    = rd_cyc;
  assign bus_we    = wr_cyc;
  assign bus_addr  = rd_cyc ? src_q : (wr_cyc ? dst_q : '0);
  assign bus_wdata = wr_cyc ? data_q : '0;
endmodule

// File: rtl/dma_handshake_ctrl_chk.sv
module dma_handshake_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          per_req,
  input logic          per_ack,
  input logic          bus_req,
  input logic          bus_grant,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_we,
  input logic [DW-1:0] bus_wdata,
  input logic          done
);
  // R9
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant |-> (!bus_rd && !bus_we && bus_addr == '0 && bus_wdata == '0));

  // R5
  release_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_ack) |-> $fell(bus_req));

  // R3
  ack_under_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> bus_req);

  // R4
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> $past(bus_rd));

  // R6
  fresh_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> ($past(per_req) && !$past(bus_grant)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dma_handshake_ctrl dma_handshake_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/dma_handshake_ctrl_test.sv
module dma_handshake_ctrl_test;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cfg_we = 0, cfg_sel = 0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          per_req = 0, bus_grant = 0;
  logic          per_ack, bus_req, bus_rd, bus_we, done;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction
  assign bus_rdata = bus_rd ? mem_val(bus_addr) : '0;

  dma_handshake_ctrl #(.AW(AW), .DW(DW)) uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input bit sel, input logic [AW-1:0] v);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xfer(input logic [AW-1:0] s, input logic [AW-1:0] d,
                      input int gwait, input int req_hold, input bit corrupt);
    cfg(0, s); cfg(1, d);
    per_req = 1;
    @(negedge clk);
    chk(bus_req && !per_ack, "R2 bus_req raised", {bus_req, per_ack}, 2'b10);
    for (int i = 0; i < gwait; i++) begin
      if (corrupt && i == 0) begin
        cfg_we = 1; cfg_sel = 0; cfg_wdata = 16'hDEAD;
      end else if (corrupt && i == 1) begin
        cfg_we = 1; cfg_sel = 1; cfg_wdata = 16'hBEEF;
      end
      @(negedge clk);
      cfg_we = 0;
      chk(!per_ack && !bus_rd && !bus_we && bus_addr == 0, "R2 wait for grant",
          {per_ack, bus_rd, bus_we, bus_addr}, 0);
    end
    bus_grant = 1;
    @(negedge clk);
    chk(per_ack && bus_rd && !bus_we, "R3 ack and read", {per_ack, bus_rd, bus_we}, 3'b110);
    chk(bus_addr == s, corrupt ? "R8 src kept" : "R3 src addr", bus_addr, s);
    @(negedge clk);
    chk(bus_we && !bus_rd && per_ack, "R4 write strobe", {bus_we, bus_rd, per_ack}, 3'b101);
    chk(bus_addr == d, corrupt ? "R8 dst kept" : "R4 dst addr", bus_addr, d);
    chk(bus_wdata == mem_val(s), "R4 data copied", bus_wdata, mem_val(s));
    @(negedge clk);
    chk(!bus_req && !per_ack, "R5 release together", {bus_req, per_ack}, 0);
    chk(!done, "R7 no early done", done, 0);
    bus_grant = 0;
    for (int i = 0; i < req_hold; i++) begin
      @(negedge clk);
      chk(!bus_req && !done, "R6 stale req ignored", {bus_req, done}, 0);
    end
    per_req = 0;
    @(negedge clk);
    chk(done, "R7 done pulse", done, 1);
    chk(!bus_req && !per_ack, "R6 idle after done", {bus_req, per_ack}, 0);
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
  endtask

  task automatic reset_test();
    @(negedge clk);
    chk({bus_req, per_ack, bus_rd, bus_we, done} == 0 && bus_addr == 0 && bus_wdata == 0,
        "R1 reset outputs", {bus_req, per_ack, bus_rd, bus_we, done}, 0);
  endtask

  task automatic quiet_test();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!bus_req && !bus_rd && !bus_we && bus_addr == 0 && bus_wdata == 0,
          "R9 quiet without grant", {bus_req, bus_rd, bus_we}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    reset_test();
    quiet_test();
    xfer(16'h8000, 16'h0001, 0, 0, 0);
    xfer(16'h1234, 16'hABCD, 3, 0, 0);
    xfer(16'h00F0, 16'h0F00, 2, 4, 0);
    xfer(16'h7777, 16'h2222, 3, 1, 1);
    xfer(16'hFFFF, 16'h0000, 1, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule